// File: doc/BRIEF.md
# Modem handshake and auto-enable controller

This block drives the modem handshake outputs of one serial channel and turns the handshake inputs into enables for that channel's transmitter and receiver. The CPU register file supplies the request-to-send bit, the terminal-ready bit, an auto-enable switch, the protocol mode, an automatic RTS release switch for bit-oriented framing, and a selector that lends the terminal-ready pin to a DMA engine as a request line. The transmitter reports when it has drained and when the last bit of a closing flag has left the line.

The clear-to-send and carrier-detect pins are asynchronous and active low. Each one passes through a synchroniser chain and an edge detector. A level change in either direction sets a sticky pending flag, which raises the external/status interrupt request. With auto-enable on, the synchronised levels gate the transmitter and the receiver. The request-to-send pin can keep the line claimed after software clears its bit. In asynchronous auto-enable mode it holds until the transmitter is empty. In bit-oriented mode with automatic release it holds until the closing flag has gone out.

Top module: `modem_ctl`

## Requirements
- R1: While `chan_rst_i` is low and `rts_bit_i` is 1, `rts_no` is 0 in the same cycle.
- R2: The mode code on `mode_i` is 0 for asynchronous, 1 for character-synchronous, 2 for bit-oriented (flag) framing, and 3 acts as character-synchronous. In asynchronous mode with `auto_en_i` set, after `rts_bit_i` falls `rts_no` stays 0. It goes to 1 after the first rising clock edge at which `tx_empty_i` is sampled 1 with the bit still clear.
- R3: `rts_no` equals the inverse of `rts_bit_i` with no clock delay in any of these cases: character-synchronous mode; asynchronous mode with `auto_en_i` clear; bit-oriented mode with `auto_rts_rst_i` clear.
- R4: In bit-oriented mode with `auto_rts_rst_i` set, after `rts_bit_i` falls `rts_no` stays 0, and `tx_empty_i` has no effect on it. It goes to 1 after the first rising edge at which `flag_done_i` is sampled 1.
- R5: With `auto_en_i` set, `tx_en_o` is 1 exactly when the synchronised clear-to-send level is asserted (pin low). With `auto_en_i` clear, `tx_en_o` is 1 whatever the pin does.
- R6: With `auto_en_i` set, `rx_en_o` is 1 exactly when the synchronised carrier-detect level is asserted (pin low). With `auto_en_i` clear, `rx_en_o` is 1 whatever the pin does.
- R7: `cts_o` and `dcd_o` are 1 when their pin is low. A pin change driven between edges appears on them after the second following rising edge, with the default two synchroniser stages.
- R8: A level change in either direction on `cts_o` or `dcd_o` sets `cts_pend_o` or `dcd_pend_o` at the next rising edge. The flag stays set until a cycle with `int_ack_i` high and no new change. `ext_irq_o` is the OR of both flags.
- R9: When `dtr_req_sel_i` is 0, `dtr_req_no` is the inverse of `dtr_bit_i`. When it is 1, `dtr_req_no` is the inverse of `dma_req_i` and `dtr_bit_i` has no effect.
- R10: While `chan_rst_i` is high, `rts_no` and `dtr_req_no` are 1 and `tx_en_o` and `rx_en_o` are 0. Both pending flags are clear after the edge, and any deferred RTS hold is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chan_rst_i | input | 1 | Synchronous channel reset |
| rts_bit_i | input | 1 | Request-to-send control bit |
| dtr_bit_i | input | 1 | Terminal-ready control bit |
| auto_en_i | input | 1 | Auto-enable switch |
| mode_i | input | 2 | Protocol mode code |
| auto_rts_rst_i | input | 1 | Release RTS after closing flag in bit-oriented mode |
| dtr_req_sel_i | input | 1 | Use terminal-ready pin as DMA request |
| dma_req_i | input | 1 | DMA request, active high |
| cts_ni | input | 1 | Clear-to-send pin, active low, asynchronous |
| dcd_ni | input | 1 | Carrier-detect pin, active low, asynchronous |
| tx_empty_i | input | 1 | Transmitter fully drained |
| flag_done_i | input | 1 | Closing flag has left the line |
| int_ack_i | input | 1 | Clear pending external/status flags |
| rts_no | output | 1 | Request-to-send pin, active low |
| dtr_req_no | output | 1 | Terminal-ready / DMA request pin, active low |
| tx_en_o | output | 1 | Transmitter enable qualifier |
| rx_en_o | output | 1 | Receiver enable qualifier |
| cts_o | output | 1 | Synchronised clear-to-send, active high |
| dcd_o | output | 1 | Synchronised carrier-detect, active high |
| cts_pend_o | output | 1 | Clear-to-send change pending |
| dcd_pend_o | output | 1 | Carrier-detect change pending |
| ext_irq_o | output | 1 | External/status interrupt request |

## Verification
The hold properties for the deferred RTS release assume that the mode, auto-enable and release switches stay put while a hold is in progress. Each property therefore lists a mode change or a channel reset as an escape. The bench changes configuration only while `rts_bit_i` is set or no deferred mode is selected. The edge and latency checks assume the handshake pins never change faster than the synchroniser depth. The bench moves `cts_ni` and `dcd_ni` only at falling edges and leaves them still for at least three cycles. Transmitter status inputs are held low except in the cycles that test the release.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  typedef enum logic [1:0] {
    MODE_ASYNC = 2'd0,
    MODE_CSYNC = 2'd1,
    MODE_FLAG  = 2'd2,
    MODE_RSVD  = 2'd3
  } mdm_mode_e;

  localparam int unsigned LINE_CTS = 0;
  localparam int unsigned LINE_DCD = 1;
  localparam int unsigned NUM_LINES = 2;
endpackage

// File: rtl/mdm_line.sv
module mdm_line #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_ni,
  input  logic clr_i,
  input  logic ack_i,
  output logic active_o,
  output logic pend_o
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   pend_q;
  logic                   chg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], pin_ni};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= sync_q[LAST];
  end

  assign chg = sync_q[LAST] ^ prev_q;

  // a new change beats the acknowledge so no event is lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pend_q <= 1'b0;
    else if (clr_i) pend_q <= 1'b0;
    else if (chg)   pend_q <= 1'b1;
    else if (ack_i) pend_q <= 1'b0;
  end

  assign active_o = ~sync_q[LAST];
  assign pend_o   = pend_q;
endmodule

// File: rtl/mdm_rts_ctl.sv
module mdm_rts_ctl
  import mdm_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      chan_rst_i,
  input  logic      rts_bit_i,
  input  mdm_mode_e mode_i,
  input  logic      auto_en_i,
  input  logic      auto_rts_rst_i,
  input  logic      tx_empty_i,
  input  logic      flag_done_i,
  output logic      rts_no
);
  logic hold_q;
  logic defer;
  logic release_ok;

  always_comb begin
    defer      = 1'b0;
    release_ok = 1'b1;
    unique case (mode_i)
      MODE_ASYNC: begin
        defer      = auto_en_i;
        release_ok = tx_empty_i;
      end
      MODE_FLAG: begin
        defer      = auto_rts_rst_i;
        release_ok = flag_done_i;
      end
      default: begin
        defer      = 1'b0;
        release_ok = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          hold_q <= 1'b0;
    else if (chan_rst_i)  hold_q <= 1'b0;
    else if (rts_bit_i)   hold_q <= 1'b1;
    else if (!defer)      hold_q <= 1'b0;
    else if (release_ok)  hold_q <= 1'b0;
  end

  assign rts_no = chan_rst_i | ~(rts_bit_i | (hold_q & defer));
endmodule

// File: rtl/modem_ctl.sv
module modem_ctl
  import mdm_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       chan_rst_i,
  input  logic       rts_bit_i,
  input  logic       dtr_bit_i,
  input  logic       auto_en_i,
  input  logic [1:0] mode_i,
  input  logic       auto_rts_rst_i,
  input  logic       dtr_req_sel_i,
  input  logic       dma_req_i,
  input  logic       cts_ni,
  input  logic       dcd_ni,
  input  logic       tx_empty_i,
  input  logic       flag_done_i,
  input  logic       int_ack_i,
  output logic       rts_no,
  output logic       dtr_req_no,
  output logic       tx_en_o,
  output logic       rx_en_o,
  output logic       cts_o,
  output logic       dcd_o,
  output logic       cts_pend_o,
  output logic       dcd_pend_o,
  output logic       ext_irq_o
);
  logic [NUM_LINES-1:0] pins_n;
  logic [NUM_LINES-1:0] act;
  logic [NUM_LINES-1:0] pend;
  mdm_mode_e            mode;

  assign mode              = mdm_mode_e'(mode_i);
  assign pins_n[LINE_CTS]  = cts_ni;
  assign pins_n[LINE_DCD]  = dcd_ni;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    mdm_line #(.SYNC_STAGES(SYNC_STAGES)) u_line (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .pin_ni   (pins_n[g]),
      .clr_i    (chan_rst_i),
      .ack_i    (int_ack_i),
      .active_o (act[g]),
      .pend_o   (pend[g])
    );
  end

  mdm_rts_ctl u_rts (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .chan_rst_i     (chan_rst_i),
    .rts_bit_i      (rts_bit_i),
    .mode_i         (mode),
    .auto_en_i      (auto_en_i),
    .auto_rts_rst_i (auto_rts_rst_i),
    .tx_empty_i     (tx_empty_i),
    .flag_done_i    (flag_done_i),
    .rts_no         (rts_no)
  );

  assign dtr_req_no = chan_rst_i | (dtr_req_sel_i ? ~dma_req_i : ~dtr_bit_i);
  assign cts_o      = act[LINE_CTS];
  assign dcd_o      = act[LINE_DCD];
  assign tx_en_o    = ~chan_rst_i & (~auto_en_i | act[LINE_CTS]);
  assign rx_en_o    = ~chan_rst_i & (~auto_en_i | act[LINE_DCD]);
  assign cts_pend_o = pend[LINE_CTS];
  assign dcd_pend_o = pend[LINE_DCD];
  assign ext_irq_o  = |pend;
endmodule

// File: rtl/modem_ctl_chk.sv
module modem_ctl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       chan_rst_i,
  input logic       rts_bit_i,
  input logic       dtr_bit_i,
  input logic       auto_en_i,
  input logic [1:0] mode_i,
  input logic       auto_rts_rst_i,
  input logic       dtr_req_sel_i,
  input logic       dma_req_i,
  input logic       tx_empty_i,
  input logic       flag_done_i,
  input logic       int_ack_i,
  input logic       rts_no,
  input logic       dtr_req_no,
  input logic       tx_en_o,
  input logic       rx_en_o,
  input logic       cts_o,
  input logic       dcd_o,
  input logic       cts_pend_o,
  input logic       dcd_pend_o
);
  AST_RTS_SET_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rts_bit_i && !chan_rst_i) |-> !rts_no); // R1

  AST_RTS_ASYNC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd0 && auto_en_i && !rts_bit_i && !tx_empty_i && !rts_no && !chan_rst_i)
    |=> (!rts_no || chan_rst_i || mode_i != 2'd0 || !auto_en_i)); // R2

  AST_RTS_DIRECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!chan_rst_i && (mode_i[0] || (mode_i == 2'd0 && !auto_en_i) || (mode_i == 2'd2 && !auto_rts_rst_i)))
    |-> (rts_no == !rts_bit_i)); // R3

  AST_RTS_FLAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd2 && auto_rts_rst_i && !rts_bit_i && !flag_done_i && !rts_no && !chan_rst_i)
    |=> (!rts_no || chan_rst_i || mode_i != 2'd2 || !auto_rts_rst_i)); // R4

  AST_TX_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_en_i && !cts_o) |-> !tx_en_o); // R5

  AST_RX_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_en_i && !dcd_o) |-> !rx_en_o); // R6

  AST_CTS_CHG_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(cts_o) && !chan_rst_i) |=> (cts_pend_o || chan_rst_i)); // R8

  AST_CTS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cts_pend_o && !int_ack_i && !chan_rst_i) |=> cts_pend_o); // R8

  AST_DCD_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dcd_pend_o && !int_ack_i && !chan_rst_i) |=> dcd_pend_o); // R8

  AST_DTR_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!chan_rst_i && !dtr_req_sel_i) |-> (dtr_req_no == !dtr_bit_i)); // R9

  AST_DTR_DMA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!chan_rst_i && dtr_req_sel_i) |-> (dtr_req_no == !dma_req_i)); // R9

  AST_CHAN_RST_PINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chan_rst_i |-> (rts_no && dtr_req_no && !tx_en_o && !rx_en_o)); // R10

  AST_CHAN_RST_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chan_rst_i |=> (!cts_pend_o && !dcd_pend_o)); // R10
endmodule

bind modem_ctl modem_ctl_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .chan_rst_i     (chan_rst_i),
  .rts_bit_i      (rts_bit_i),
  .dtr_bit_i      (dtr_bit_i),
  .auto_en_i      (auto_en_i),
  .mode_i         (mode_i),
  .auto_rts_rst_i (auto_rts_rst_i),
  .dtr_req_sel_i  (dtr_req_sel_i),
  .dma_req_i      (dma_req_i),
  .tx_empty_i     (tx_empty_i),
  .flag_done_i    (flag_done_i),
  .int_ack_i      (int_ack_i),
  .rts_no         (rts_no),
  .dtr_req_no     (dtr_req_no),
  .tx_en_o        (tx_en_o),
  .rx_en_o        (rx_en_o),
  .cts_o          (cts_o),
  .dcd_o          (dcd_o),
  .cts_pend_o     (cts_pend_o),
  .dcd_pend_o     (dcd_pend_o)
);

// File: tb/tb_modem_ctl.sv
`timescale 1ns/1ps
module tb_modem_ctl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chan_rst = 0, rts_bit = 0, dtr_bit = 0, auto_en = 0, arr = 0;
  logic [1:0] mode = 2'd0;
  logic sel = 0, dma = 0, cts_n = 1, dcd_n = 1, tx_empty = 0, flag_done = 0, ack = 0;
  logic rts_n, dtr_n, tx_en, rx_en, cts, dcd, cts_p, dcd_p, irq;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  modem_ctl dut (
    .clk_i(clk), .rst_ni(rst_n), .chan_rst_i(chan_rst), .rts_bit_i(rts_bit),
    .dtr_bit_i(dtr_bit), .auto_en_i(auto_en), .mode_i(mode), .auto_rts_rst_i(arr),
    .dtr_req_sel_i(sel), .dma_req_i(dma), .cts_ni(cts_n), .dcd_ni(dcd_n),
    .tx_empty_i(tx_empty), .flag_done_i(flag_done), .int_ack_i(ack),
    .rts_no(rts_n), .dtr_req_no(dtr_n), .tx_en_o(tx_en), .rx_en_o(rx_en),
    .cts_o(cts), .dcd_o(dcd), .cts_pend_o(cts_p), .dcd_pend_o(dcd_p), .ext_irq_o(irq)
  );

  task automatic chk(string req, string what, logic act, logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // {rts, dtr, auto, arr, mode[1:0], sel, dma, exp_rts_n, exp_dtr_n, req[3:0]}
  localparam logic [13:0] VEC [8] = '{
    {1'b1,1'b0,1'b0,1'b0,2'd0,1'b0,1'b0, 1'b0,1'b1, 4'd1}, // R1
    {1'b1,1'b1,1'b1,1'b0,2'd0,1'b0,1'b0, 1'b0,1'b0, 4'd1}, // R1
    {1'b0,1'b1,1'b0,1'b0,2'd0,1'b0,1'b0, 1'b1,1'b0, 4'd3}, // R3 async, auto off
    {1'b0,1'b0,1'b1,1'b0,2'd1,1'b0,1'b0, 1'b1,1'b1, 4'd3}, // R3 char sync
    {1'b1,1'b0,1'b1,1'b1,2'd2,1'b0,1'b0, 1'b0,1'b1, 4'd1}, // R1
    {1'b0,1'b1,1'b0,1'b1,2'd1,1'b1,1'b1, 1'b1,1'b0, 4'd9}, // R9 dma request
    {1'b0,1'b1,1'b0,1'b0,2'd2,1'b1,1'b0, 1'b1,1'b1, 4'd9}, // R9 dtr bit ignored
    {1'b1,1'b0,1'b0,1'b0,2'd3,1'b1,1'b1, 1'b0,1'b0, 4'd1}  // R1 code 3
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(4);
    // reset state: R10 pins idle, R5 R6 enables with auto off
    chk("R10", "rts_n reset", rts_n, 1'b1);
    chk("R9",  "dtr_n reset", dtr_n, 1'b1);
    chk("R5",  "tx_en reset", tx_en, 1'b1);
    chk("R6",  "rx_en reset", rx_en, 1'b1);
    chk("R8",  "irq reset",   irq,   1'b0);

    foreach (VEC[i]) begin
      logic [13:0] v;
      v = VEC[i];
      {rts_bit, dtr_bit, auto_en, arr, mode, sel, dma} = v[13:6];
      cyc(1);
      chk($sformatf("R%0d", v[3:0]), $sformatf("vec %0d rts_n", i), rts_n, v[5]);
      chk($sformatf("R%0d", v[3:0]), $sformatf("vec %0d dtr_n", i), dtr_n, v[4]);
    end
    sel = 0; dma = 0; dtr_bit = 0;

    // R2 async auto-enable: hold until transmitter empty
    mode = 2'd0; auto_en = 1; arr = 0; rts_bit = 1; tx_empty = 0;
    cyc(2);
    rts_bit = 0;
    cyc(3);
    chk("R2", "held while busy", rts_n, 1'b0);
    tx_empty = 1;
    #0.5;
    chk("R2", "held before edge", rts_n, 1'b0);
    cyc(1);
    chk("R2", "released after empty", rts_n, 1'b1);
    tx_empty = 0;

    // R4 flag mode: tx_empty ignored, flag_done releases
    mode = 2'd2; auto_en = 0; arr = 1; rts_bit = 1;
    cyc(2);
    rts_bit = 0; tx_empty = 1;
    cyc(3);
    chk("R4", "tx_empty ignored", rts_n, 1'b0);
    flag_done = 1;
    cyc(1);
    flag_done = 0; tx_empty = 0;
    chk("R4", "released after flag", rts_n, 1'b1);

    // R5 R7 R8 clear-to-send path
    mode = 2'd0; arr = 0; auto_en = 1;
    cyc(1);
    chk("R5", "tx gated by idle cts", tx_en, 1'b0);
    cts_n = 0;
    cyc(1);
    chk("R7", "cts after one edge", cts, 1'b0);
    cyc(1);
    chk("R7", "cts after two edges", cts, 1'b1);
    chk("R5", "tx enabled by cts", tx_en, 1'b1);
    chk("R8", "pend not yet", cts_p, 1'b0);
    cyc(1);
    chk("R8", "cts pend on fall", cts_p, 1'b1);
    chk("R8", "irq on cts", irq, 1'b1);
    cyc(3);
    chk("R8", "cts pend sticky", cts_p, 1'b1);
    ack = 1;
    cyc(1);
    ack = 0;
    chk("R8", "cts pend cleared", cts_p, 1'b0);
    chk("R8", "irq cleared", irq, 1'b0);
    cts_n = 1;
    cyc(3);
    chk("R8", "cts pend on rise", cts_p, 1'b1);
    chk("R5", "tx gated again", tx_en, 1'b0);
    auto_en = 0;
    cyc(1);
    chk("R5", "auto off ignores cts", tx_en, 1'b1);
    ack = 1;
    cyc(1);
    ack = 0;

    // R6 carrier-detect path
    auto_en = 1;
    cyc(1);
    chk("R6", "rx gated by idle dcd", rx_en, 1'b0);
    dcd_n = 0;
    cyc(2);
    chk("R7", "dcd after two edges", dcd, 1'b1);
    chk("R6", "rx enabled by dcd", rx_en, 1'b1);
    cyc(1);
    chk("R8", "dcd pend", dcd_p, 1'b1);

    // R10 channel reset
    cts_n = 0;
    cyc(3);
    rts_bit = 1; dtr_bit = 1; chan_rst = 1;
    #0.5;
    chk("R10", "rts_n forced", rts_n, 1'b1);
    chk("R10", "dtr_n forced", dtr_n, 1'b1);
    chk("R10", "tx_en off", tx_en, 1'b0);
    chk("R10", "rx_en off", rx_en, 1'b0);
    cyc(1);
    chk("R10", "cts pend cleared", cts_p, 1'b0);
    chk("R10", "dcd pend cleared", dcd_p, 1'b0);
    rts_bit = 0;
    cyc(1);
    chan_rst = 0;
    cyc(1);
    chk("R10", "hold dropped", rts_n, 1'b1);
    chk("R5", "tx after reset", tx_en, 1'b1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule